// File: doc/BRIEF.md
# Phase-Continuous FSK/PSK Phase Accumulator

This block is the phase-generation core of a digital oscillator. Every clock it adds the active frequency control word to an `ACC_W`-bit phase register, which wraps naturally modulo 2^ACC_W. The output frequency is fcw × f_clk / 2^ACC_W, and the tuning step is f_clk / 2^ACC_W. A later amplitude stage, outside this block, consumes the resulting phase word.

Two tuning words sit at the inputs, and a one-bit FSK select picks which of them drives the accumulator. The pick is registered, so a hop takes effect one clock later. The hop never clears the register, so the phase stays continuous across it. A two-bit PSK symbol adds a quadrant offset to the register value on the way to the output. Because the offset is added outside the accumulation loop, a PSK step shifts the phase without changing the frequency.

The block also flags each wrap of the register and offers a synchronous clear of the phase.

Top module: `phase_mod_nco`

## Requirements
- R1: While `rst_ni` is low, `phase_o` and `wrap_o` are 0 and the phase register is cleared. The first output after release starts from phase 0.
- R2: Each clock, the phase register grows by the active tuning word, modulo 2^ACC_W.
- R3: `fsk_sel_i` = 0 selects `fcw0_i` and 1 selects `fcw1_i`. The choice is sampled at a clock edge and is first added at the following edge. Changing the word never resets the register.
- R4: When the addition carries out of bit ACC_W-1, `wrap_o` is high for exactly the cycle in which `phase_o` first shows the wrapped value.
- R5: `phase_o` is registered and equals the phase register value before the edge, plus an offset picked by the `psk_sym_i` sampled at that edge. Symbol 0 adds 0, 1 adds 2^(ACC_W-2), 2 adds 2^(ACC_W-1) and 3 adds 3·2^(ACC_W-2), all modulo 2^ACC_W. The offset never feeds back into the register.
- R6: `phase_clear_i` high at an edge loads 0 into the phase register in place of the sum, and no wrap is flagged for that edge.
- R7: `ACC_W` defaults to 32 and may be set from 24 to 32. At 24 bits, the phase and the wrap follow modulo 2^24 using the low 24 bits of the tuning words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fcw0_i | input | ACC_W | Tuning word used when FSK select is 0 |
| fcw1_i | input | ACC_W | Tuning word used when FSK select is 1 |
| fsk_sel_i | input | 1 | FSK symbol, picks the tuning word |
| psk_sym_i | input | 2 | PSK symbol, picks the quadrant offset |
| phase_clear_i | input | 1 | Synchronous clear of the phase register |
| phase_o | output | ACC_W | Output phase word |
| wrap_o | output | 1 | Phase register wrapped (one cycle) |

## Verification
A coarse tuning word (2^28) steps the ramp through a complete wrap in 16 clocks. This confirms both the increment and the alignment of the wrap flag with the wrapped value. A hop to a word that is not a power of two, in the middle of the ramp, separates a phase-continuous change from one that clears or delays by the wrong number of cycles. The all-ones word wraps on almost every clock and so stresses back-to-back carries. Cycling all four PSK symbols over a running ramp shows that the offset reaches the output without leaking into the register. A clear asserted while the register sits near a wrap checks that the clear overrides the carry. A 24-bit instance runs on the same stimulus to check that the modulus follows the parameter.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W_MIN = 24;
  localparam int unsigned ACC_W_MAX = 32;

  typedef enum logic [1:0] {
    PSK_Q0 = 2'd0,
    PSK_Q1 = 2'd1,
    PSK_Q2 = 2'd2,
    PSK_Q3 = 2'd3
  } psk_sym_e;
endpackage

// File: rtl/nco_fcw_select.sv
module nco_fcw_select #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] fcw0_i,
  input  logic [ACC_W-1:0] fcw1_i,
  input  logic             sel_i,
  output logic [ACC_W-1:0] fcw_o
);
  logic [ACC_W-1:0] fcw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcw_q <= '0;
    else         fcw_q <= sel_i ? fcw1_i : fcw0_i;
  end

  assign fcw_o = fcw_q;

  AST_FCW_PICK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> fcw_o == $past(fcw0_i)); // R3
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] fcw_i,
  input  logic             clear_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic             carry_q;
  logic [ACC_W:0]   sum;

  // natural modulo via dropped carry
  assign sum = {1'b0, acc_q} + {1'b0, fcw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= sum[ACC_W-1:0];
      carry_q <= sum[ACC_W];
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_o == '0); // R6
  AST_NO_WRAP_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !carry_o); // R6
  AST_WRAP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> acc_o < $past(acc_o)); // R4
endmodule

// File: rtl/nco_phase_offset.sv
module nco_phase_offset #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             carry_i,
  input  logic [1:0]       psk_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  import nco_pkg::*;

  localparam logic [ACC_W-1:0] OFF_Q1 = {2'b01, {(ACC_W-2){1'b0}}};
  localparam logic [ACC_W-1:0] OFF_Q2 = {2'b10, {(ACC_W-2){1'b0}}};
  localparam logic [ACC_W-1:0] OFF_Q3 = {2'b11, {(ACC_W-2){1'b0}}};

  logic [ACC_W-1:0] offset;
  logic [ACC_W-1:0] phase_q;
  logic             wrap_q;

  always_comb begin
    unique case (psk_sym_e'(psk_i))
      PSK_Q1:  offset = OFF_Q1;
      PSK_Q2:  offset = OFF_Q2;
      PSK_Q3:  offset = OFF_Q3;
      default: offset = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= acc_i + offset;
      wrap_q  <= carry_i;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

  AST_PSK_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psk_i == 2'd0 |=> phase_o == $past(acc_i)); // R5
endmodule

// File: rtl/phase_mod_nco.sv
module phase_mod_nco #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] fcw0_i,
  input  logic [ACC_W-1:0] fcw1_i,
  input  logic             fsk_sel_i,
  input  logic [1:0]       psk_sym_i,
  input  logic             phase_clear_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] fcw_act;
  logic [ACC_W-1:0] acc;
  logic             carry;

  nco_fcw_select #(.ACC_W(ACC_W)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fcw0_i(fcw0_i),
    .fcw1_i(fcw1_i),
    .sel_i (fsk_sel_i),
    .fcw_o (fcw_act)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fcw_i  (fcw_act),
    .clear_i(phase_clear_i),
    .acc_o  (acc),
    .carry_o(carry)
  );

  nco_phase_offset #(.ACC_W(ACC_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .carry_i(carry),
    .psk_i  (psk_sym_i),
    .phase_o(phase_o),
    .wrap_o (wrap_o)
  );
endmodule

// File: tb/phase_mod_nco_bench.sv
module phase_mod_nco_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fcw0_i = '0;
  logic [31:0] fcw1_i = '0;
  logic        fsk_sel_i = 1'b0;
  logic [1:0]  psk_sym_i = '0;
  logic        phase_clear_i = 1'b0;
  logic [31:0] phase_o;
  logic        wrap_o;
  logic [23:0] phase24;
  logic        wrap24;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  phase_mod_nco u_phase_mod_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .fcw0_i(fcw0_i), .fcw1_i(fcw1_i),
    .fsk_sel_i(fsk_sel_i), .psk_sym_i(psk_sym_i), .phase_clear_i(phase_clear_i),
    .phase_o(phase_o), .wrap_o(wrap_o)
  );

  phase_mod_nco #(.ACC_W(24)) u_phase_mod_nco_w24 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fcw0_i(fcw0_i[23:0]), .fcw1_i(fcw1_i[23:0]),
    .fsk_sel_i(fsk_sel_i), .psk_sym_i(psk_sym_i), .phase_clear_i(phase_clear_i),
    .phase_o(phase24), .wrap_o(wrap24)
  );

  typedef struct {
    logic [31:0] ph;
    logic        wr;
    logic [23:0] ph24;
    logic        wr24;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  logic [31:0] m_acc = '0, m_fcw = '0;
  logic        m_wrap = 1'b0;
  logic [23:0] m_acc24 = '0, m_fcw24 = '0;
  logic        m_wrap24 = 1'b0;

  // drive at a negedge, push what the next posedge must produce
  task automatic step(input logic [31:0] f0, input logic [31:0] f1, input logic sel,
                      input logic [1:0] sym, input logic clr, input string tag);
    exp_t e;
    logic [32:0] s;
    logic [24:0] s24;
    fcw0_i = f0; fcw1_i = f1; fsk_sel_i = sel; psk_sym_i = sym; phase_clear_i = clr;
    e.ph   = m_acc + {sym, 30'b0};
    e.wr   = m_wrap;
    e.ph24 = m_acc24 + {sym, 22'b0};
    e.wr24 = m_wrap24;
    e.tag  = tag;
    sb_q.push_back(e);
    s   = {1'b0, m_acc} + {1'b0, m_fcw};
    s24 = {1'b0, m_acc24} + {1'b0, m_fcw24};
    m_acc    = clr ? '0 : s[31:0];
    m_wrap   = clr ? 1'b0 : s[32];
    m_acc24  = clr ? '0 : s24[23:0];
    m_wrap24 = clr ? 1'b0 : s24[24];
    m_fcw    = sel ? f1 : f0;
    m_fcw24  = m_fcw[23:0];
    @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (phase_o !== e.ph || wrap_o !== e.wr) begin
        bad++;
        $display("FAIL %s: phase=%h wrap=%b expected phase=%h wrap=%b",
                 e.tag, phase_o, wrap_o, e.ph, e.wr);
      end
      total++;
      if (phase24 !== e.ph24 || wrap24 !== e.wr24) begin
        bad++;
        $display("FAIL R7 (%s): phase24=%h wrap24=%b expected phase24=%h wrap24=%b",
                 e.tag, phase24, wrap24, e.ph24, e.wr24);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    total++;
    if (phase_o !== '0 || wrap_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: phase=%h wrap=%b expected phase=0 wrap=0", phase_o, wrap_o);
    end
    rst_ni = 1'b1;

    // R2/R4: 2^28 ramp, wraps every 16 clocks
    for (int i = 0; i < 36; i++) step(32'h1000_0000, 32'h0300_0000, 1'b0, 2'd0, 1'b0, "R2/R4 ramp");
    // R3: hop mid-ramp to a non power-of-two word, then back
    for (int i = 0; i < 10; i++) step(32'h1000_0000, 32'h0300_0001, 1'b1, 2'd0, 1'b0, "R3 hop to fcw1");
    for (int i = 0; i < 6; i++)  step(32'h1000_0000, 32'h0300_0001, 1'b0, 2'd0, 1'b0, "R3 hop back");
    // R5: all PSK symbols over a running ramp
    for (int i = 0; i < 16; i++) step(32'h0123_4567, 32'h0, 1'b0, 2'(i), 1'b0, "R5 psk offset");
    // R6: clear while near a wrap
    for (int i = 0; i < 6; i++) step(32'hF000_0000, 32'h0, 1'b0, 2'd1, 1'b0, "R6 pre-clear");
    step(32'hF000_0000, 32'h0, 1'b0, 2'd0, 1'b1, "R6 clear");
    step(32'hF000_0000, 32'h0, 1'b0, 2'd0, 1'b1, "R6 clear held");
    for (int i = 0; i < 4; i++) step(32'hF000_0000, 32'h0, 1'b0, 2'd0, 1'b0, "R6 post-clear");
    // R4/R2: all-ones word wraps back to back
    for (int i = 0; i < 8; i++) step(32'hFFFF_FFFF, 32'h0, 1'b0, 2'd2, 1'b0, "R4 back-to-back wrap");
    // R1: reset mid-run, restart from zero
    rst_ni = 1'b0;
    m_acc = '0; m_fcw = '0; m_wrap = 1'b0; m_acc24 = '0; m_fcw24 = '0; m_wrap24 = 1'b0;
    sb_q.delete();
    @(negedge clk_i);
    total++;
    if (phase_o !== '0 || wrap_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: phase=%h wrap=%b expected phase=0 wrap=0 after mid-run reset", phase_o, wrap_o);
    end
    fcw0_i = '0; fcw1_i = '0; fsk_sel_i = 1'b0; psk_sym_i = '0; phase_clear_i = 1'b0;
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) step(32'h4000_0000, 32'h0, 1'b0, 2'd3, 1'b0, "R1 restart");
    for (int i = 0; i < 3; i++) step(32'h0, 32'h0, 1'b0, 2'd0, 1'b0, "R2 zero word");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule